// File: doc/BRIEF.md
# Overcurrent Run Counter and Hiccup Restart Controller

This block supervises a buck regulator and its companion linear regulator one switching cycle at a time. It watches a peak overcurrent flag, a negative (valley) current flag and a linear-regulator overcurrent flag. A strobe marks each switching cycle start and a slow timebase tick sets the scale of the wait intervals. For each cycle it decides whether the high-side switch must stay blanked. It keeps separate run counters of consecutive overcurrent and negative-current cycles, and it sequences the recovery from either kind of event.

A long run of overcurrent cycles, or any linear-regulator overcurrent, shuts the regulator down and raises a fault. The block then waits a fixed number of ticks, resets its counters and issues a one-clock soft-start request. Two consecutive negative-current cycles open both power switches and enable the discharge resistor until the output is reported back in regulation. After that, light-load pulse-skipping operation is forced for a programmable number of ticks before normal PWM is allowed again.

Top module: `ocp_hiccup_ctrl`

## Requirements
- R1: When `oc_peak` is high in a clock with switching allowed, `hs_blank` is high from the next clock edge on. It stays high until a clock where `cyc_start` is high and `oc_peak` is low.
- R2: A switching cycle (from one `cyc_start` clock up to the next) with no `oc_peak` ends the overcurrent run. A run shorter than `OC_LIMIT` (17 by default) cycles never shuts the regulator down, and the next run counts again from one.
- R3: The clock that holds the `OC_LIMIT`-th overcurrent detection of consecutive cycles is followed two clock edges later by `reg_shdn` and `fault` both high.
- R4: During shutdown, `reg_shdn` and `fault` stay high until `HICCUP_TICKS` clocks with `tick` high have been counted. On the edge after the last counted tick, `ss_req` is high for exactly one clock, and `fault` and `reg_shdn` are low in that clock.
- R5: After the soft-start request, the run counters restart from zero: `OC_LIMIT`-1 further overcurrent cycles do not shut down, but `OC_LIMIT` do.
- R6: `ldo_oc` high in a clock while switching is allowed gives `reg_shdn` and `fault` high on the next edge, followed by the same hiccup wait and restart as R4.
- R7: The second of two consecutive cycles flagged by `neg_valley` (run limit `NEG_LIMIT`, 2 by default) is followed two edges later by `fets_off` and `dis_en` high, with `hs_blank` high. Two flagged cycles with a clean cycle between them do not do this.
- R8: While `fets_off` is high, `in_reg` high drops `fets_off` and `dis_en` on the next edge and raises `pfm_force`. `pfm_force` stays high until `PFM_TICKS` ticks have been counted, and falls on the edge after the last one.
- R9: During and right after reset, all outputs are low.
- R10: `ldo_oc` while both switches are held off by a negative-current event moves the block to shutdown: `reg_shdn` and `fault` high, `fets_off` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cyc_start | input | 1 | One-clock strobe at the start of each switching cycle |
| oc_peak | input | 1 | High-side peak overcurrent detected |
| neg_valley | input | 1 | Valley current reached the negative limit |
| ldo_oc | input | 1 | Linear regulator overcurrent |
| in_reg | input | 1 | Output voltage back inside its regulation window |
| tick | input | 1 | Timebase tick, one clock wide |
| hs_blank | output | 1 | Keep the high-side switch off |
| fets_off | output | 1 | Both power switches off |
| dis_en | output | 1 | Enable the output discharge resistor |
| reg_shdn | output | 1 | Regulator shutdown (hiccup wait) |
| ss_req | output | 1 | One-clock soft-start request |
| fault | output | 1 | Overcurrent fault present |
| pfm_force | output | 1 | Force pulse-skipping mode |

## Verification
Overcurrent runs of every length from one to the trip limit are swept, each closed by clean cycles. This separates an off-by-one in the run limit from a counter that fails to clear between runs. Split runs (limit-1 cycles, one clean cycle, limit-1 again) show that a single clean cycle breaks the run. A detection in the middle of a cycle, as opposed to one at the cycle strobe, shows that blanking holds for the rest of the cycle and is released at the next clean strobe. Tick sweeps through the hiccup and pulse-skipping windows find the exact release edge, and negative-current pairs, both back-to-back and split by a clean cycle, show the two-cycle rule.

// File: rtl/ocp_pkg.sv
// Shared types for the overcurrent protection controller.
package ocp_pkg;
    // Protection sequencer states.
    typedef enum logic [2:0] {
        ST_RUN      = 3'd0,
        ST_NEG_OFF  = 3'd1,
        ST_PFM_HOLD = 3'd2,
        ST_HICCUP   = 3'd3,
        ST_RESTART  = 3'd4
    } prot_state_t;
endpackage

// File: rtl/ocp_run_counter.sv
// Consecutive-cycle event counter.
// Counts switching cycles in a row that contain at least one hit. A cycle is
// the span from one cyc_start clock up to the next. A hit in the cyc_start
// clock belongs to the cycle that starts there. The count saturates at LIMIT.
// Assumes cyc_start is a one-clock strobe and clear wins over everything else.
module ocp_run_counter #(
    parameter int LIMIT = 17,
    localparam int W = $clog2(LIMIT + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         cyc_start,
    input  logic         hit,
    output logic [W-1:0] count,
    output logic         reached
);
    logic         seen_q;
    logic [W-1:0] base;
    logic [W:0]   sum;
    logic [W-1:0] sat;

    // Count carried into the step: kept only if the cycle now ending had a hit.
    always_comb begin
        base = cyc_start ? (seen_q ? count : '0) : count;
        sum  = {1'b0, base} + (W+1)'(1);
        sat  = (sum > (W+1)'(LIMIT)) ? W'(LIMIT) : sum[W-1:0];
    end

    // Run length and per-cycle hit flag.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            count  <= '0;
            seen_q <= 1'b0;
        end else if (cyc_start) begin
            count  <= hit ? sat : base;
            seen_q <= hit;
        end else if (hit && !seen_q) begin
            count  <= sat;
            seen_q <= 1'b1;
        end
    end

    assign reached = (count == W'(LIMIT));

    AST_RUN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (count != $past(count)) |-> ((count == $past(count) + W'(1)) || (count <= W'(1)))); // R2
endmodule

// File: rtl/ocp_tick_timer.sv
// Tick-counting interval timer.
// Counts timebase ticks up to a target chosen by the caller. Clear restarts it
// from zero. done is high once the target has been reached. Assumes target
// is not changed while the timer runs without a clear in between.
module ocp_tick_timer #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         tick,
    input  logic [W-1:0] target,
    output logic         done
);
    logic [W-1:0] count;

    // Tick accumulator, stops at the target.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            count <= '0;
        end else if (tick && (count < target)) begin
            count <= count + W'(1);
        end
    end

    assign done = (count >= target);

    AST_TMR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !tick) |=> $stable(count)); // R4
endmodule

// File: rtl/ocp_hiccup_ctrl.sv
// Overcurrent run counter and hiccup restart controller.
// Blanks the high side for the rest of a cycle after a peak overcurrent. It
// declares a fault after OC_LIMIT overcurrent cycles in a row or on a linear
// regulator overcurrent, waits HICCUP_TICKS ticks, then requests soft-start.
// NEG_LIMIT negative-current cycles in a row open both switches until in_reg.
// After that, pulse skipping is forced for PFM_TICKS ticks.
// Assumes all inputs are synchronous to clk and tick is one clock wide.
module ocp_hiccup_ctrl
    import ocp_pkg::*;
#(
    parameter int OC_LIMIT     = 17,
    parameter int NEG_LIMIT    = 2,
    parameter int HICCUP_TICKS = 600,
    parameter int PFM_TICKS    = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cyc_start,
    input  logic oc_peak,
    input  logic neg_valley,
    input  logic ldo_oc,
    input  logic in_reg,
    input  logic tick,
    output logic hs_blank,
    output logic fets_off,
    output logic dis_en,
    output logic reg_shdn,
    output logic ss_req,
    output logic fault,
    output logic pfm_force
);
    localparam int OC_W    = $clog2(OC_LIMIT + 1);
    localparam int NEG_W   = $clog2(NEG_LIMIT + 1);
    localparam int TMR_MAX = (HICCUP_TICKS > PFM_TICKS) ? HICCUP_TICKS : PFM_TICKS;
    localparam int TMR_W   = $clog2(TMR_MAX + 1);

    prot_state_t      state_q, state_d;
    logic             switching;
    logic             cnt_clear;
    logic [OC_W-1:0]  oc_count;
    logic [NEG_W-1:0] neg_count;
    logic             oc_reached, neg_reached;
    logic             tmr_clear, tmr_done;
    logic [TMR_W-1:0] tmr_target;
    logic             blank_q;

    assign switching = (state_q == ST_RUN) || (state_q == ST_PFM_HOLD);
    assign cnt_clear = !switching;

    ocp_run_counter #(.LIMIT(OC_LIMIT)) u_oc_run (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (cnt_clear),
        .cyc_start (cyc_start),
        .hit       (oc_peak),
        .count     (oc_count),
        .reached   (oc_reached)
    );

    ocp_run_counter #(.LIMIT(NEG_LIMIT)) u_neg_run (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (cnt_clear),
        .cyc_start (cyc_start),
        .hit       (neg_valley),
        .count     (neg_count),
        .reached   (neg_reached)
    );

    // Timer runs only while a timed state is held; any state change restarts it.
    always_comb begin
        tmr_target = (state_q == ST_HICCUP) ? TMR_W'(HICCUP_TICKS) : TMR_W'(PFM_TICKS);
        tmr_clear  = !(((state_q == ST_HICCUP) || (state_q == ST_PFM_HOLD))
                       && (state_d == state_q));
    end

    ocp_tick_timer #(.W(TMR_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (tmr_clear),
        .tick   (tick),
        .target (tmr_target),
        .done   (tmr_done)
    );

    // Sequencer next state: faults first, then negative current, then timeouts.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN, ST_PFM_HOLD: begin
                if (ldo_oc || oc_reached) begin
                    state_d = ST_HICCUP;
                end else if (neg_reached) begin
                    state_d = ST_NEG_OFF;
                end else if ((state_q == ST_PFM_HOLD) && tmr_done) begin
                    state_d = ST_RUN;
                end
            end
            ST_NEG_OFF: begin
                if (ldo_oc) begin
                    state_d = ST_HICCUP;
                end else if (in_reg) begin
                    state_d = ST_PFM_HOLD;
                end
            end
            ST_HICCUP: begin
                if (tmr_done) begin
                    state_d = ST_RESTART;
                end
            end
            ST_RESTART: state_d = ST_RUN;
            default:    state_d = ST_RUN;
        endcase
    end

    // Sequencer state register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    // Per-cycle high-side blank: set on detection, released by a clean cycle start.
    always_ff @(posedge clk) begin
        if (!rst_n || !switching) begin
            blank_q <= 1'b0;
        end else if (oc_peak) begin
            blank_q <= 1'b1;
        end else if (cyc_start) begin
            blank_q <= 1'b0;
        end
    end

    // Moore decode of the sequencer outputs.
    always_comb begin
        hs_blank  = blank_q || (state_q == ST_NEG_OFF) || (state_q == ST_HICCUP);
        fets_off  = (state_q == ST_NEG_OFF);
        dis_en    = (state_q == ST_NEG_OFF);
        reg_shdn  = (state_q == ST_HICCUP);
        fault     = (state_q == ST_HICCUP);
        ss_req    = (state_q == ST_RESTART);
        pfm_force = (state_q == ST_PFM_HOLD);
    end

    AST_BLANK_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (oc_peak && switching) |=> hs_blank); // R1
    AST_TRIP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(reg_shdn) |-> $past(oc_reached || ldo_oc)); // R3
    AST_FAULT_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fault) |-> ss_req); // R4
    AST_SS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        ss_req |=> !ss_req); // R4
    AST_NEG_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fets_off) |-> $past(neg_reached)); // R7
    AST_PFM_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pfm_force) |-> $past(in_reg)); // R8
endmodule

// File: tb/ocp_hiccup_ctrl_tb.sv
module ocp_hiccup_ctrl_tb;
    localparam int OCL = 17;
    localparam int HT  = 8;
    localparam int PT  = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cyc_start = 0, oc_peak = 0, neg_valley = 0, ldo_oc = 0, in_reg = 0, tick = 0;
    logic hs_blank, fets_off, dis_en, reg_shdn, ss_req, fault, pfm_force;
    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    ocp_hiccup_ctrl #(.OC_LIMIT(OCL), .NEG_LIMIT(2), .HICCUP_TICKS(HT), .PFM_TICKS(PT)) u_dut (
        .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .oc_peak(oc_peak),
        .neg_valley(neg_valley), .ldo_oc(ldo_oc), .in_reg(in_reg), .tick(tick),
        .hs_blank(hs_blank), .fets_off(fets_off), .dis_en(dis_en), .reg_shdn(reg_shdn),
        .ss_req(ss_req), .fault(fault), .pfm_force(pfm_force)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    // One switching cycle of three clocks; flags ride on the cycle-start clock.
    task automatic cyc(input logic oc, input logic ng);
        cyc_start = 1'b1; oc_peak = oc; neg_valley = ng;
        @(negedge clk);
        cyc_start = 1'b0; oc_peak = 1'b0; neg_valley = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic pulse_tick();
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        @(negedge clk);
    endtask

    // Wait out the hiccup window and confirm the restart pulse.
    task automatic hiccup_walk(input string req);
        for (int k = 1; k <= HT; k++) begin
            pulse_tick();
            if (k < HT) begin
                check({req, " fault held"}, fault, 1'b1);
                check({req, " shdn held"}, reg_shdn, 1'b1);
                check({req, " no early ss"}, ss_req, 1'b0);
            end
        end
        check({req, " R4 ss_req"}, ss_req, 1'b1);
        check({req, " R4 fault cleared"}, fault, 1'b0);
        check({req, " R4 shdn cleared"}, reg_shdn, 1'b0);
        @(negedge clk);
        check({req, " R4 ss one clock"}, ss_req, 1'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R9 reset fault", fault, 1'b0);
        check("R9 reset shdn", reg_shdn, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 blank", hs_blank, 1'b0);
        check("R9 fets_off", fets_off, 1'b0);
        check("R9 dis_en", dis_en, 1'b0);
        check("R9 ss_req", ss_req, 1'b0);
        check("R9 pfm", pfm_force, 1'b0);

        // R1: detection in mid-cycle holds blank until a clean cycle start
        oc_peak = 1'b1;
        @(negedge clk);
        oc_peak = 1'b0;
        check("R1 blank set", hs_blank, 1'b1);
        @(negedge clk);
        check("R1 blank held", hs_blank, 1'b1);
        cyc(1'b0, 1'b0);
        check("R1 blank released", hs_blank, 1'b0);
        cyc(1'b0, 1'b0);

        // R2/R3: sweep run lengths 1..OCL, trip expected only at OCL
        for (int n = 1; n <= OCL; n++) begin
            for (int i = 1; i <= n; i++) begin
                cyc(1'b1, 1'b0);
                check((i >= OCL) ? "R3 trip shdn" : "R2 no trip", reg_shdn, (i >= OCL));
                check((i >= OCL) ? "R3 trip fault" : "R2 no fault", fault, (i >= OCL));
            end
            if (n < OCL) begin
                check("R1 blank after oc cycle", hs_blank, 1'b1);
                cyc(1'b0, 1'b0);
                cyc(1'b0, 1'b0);
            end
        end
        hiccup_walk("R3");

        // R2: split runs do not add up
        for (int i = 0; i < OCL - 1; i++) cyc(1'b1, 1'b0);
        cyc(1'b0, 1'b0);
        for (int i = 0; i < OCL - 1; i++) cyc(1'b1, 1'b0);
        check("R2 split run", reg_shdn, 1'b0);
        cyc(1'b0, 1'b0);
        cyc(1'b0, 1'b0);

        // R5: restart clears the count
        for (int i = 1; i <= OCL; i++) begin
            cyc(1'b1, 1'b0);
            check("R5 count from zero", reg_shdn, (i == OCL));
        end
        hiccup_walk("R5");

        // R6: linear regulator overcurrent
        ldo_oc = 1'b1;
        @(negedge clk);
        ldo_oc = 1'b0;
        check("R6 shdn", reg_shdn, 1'b1);
        check("R6 fault", fault, 1'b1);
        hiccup_walk("R6");

        // R7: split negative cycles do nothing, back-to-back ones open the switches
        cyc(1'b0, 1'b1);
        cyc(1'b0, 1'b0);
        cyc(1'b0, 1'b0);
        cyc(1'b0, 1'b1);
        check("R7 split neg", fets_off, 1'b0);
        cyc(1'b0, 1'b0);
        cyc(1'b0, 1'b0);
        cyc(1'b0, 1'b1);
        check("R7 single neg", fets_off, 1'b0);
        cyc(1'b0, 1'b1);
        check("R7 fets_off", fets_off, 1'b1);
        check("R7 dis_en", dis_en, 1'b1);
        check("R7 blank", hs_blank, 1'b1);

        // R8: back in regulation, then forced pulse skipping for PT ticks
        in_reg = 1'b1;
        @(negedge clk);
        in_reg = 1'b0;
        check("R8 fets released", fets_off, 1'b0);
        check("R8 discharge off", dis_en, 1'b0);
        check("R8 pfm on", pfm_force, 1'b1);
        for (int k = 1; k <= PT; k++) begin
            pulse_tick();
            check("R8 pfm window", pfm_force, (k < PT));
        end

        // R10: linear overcurrent during negative-current hold
        cyc(1'b0, 1'b1);
        cyc(1'b0, 1'b1);
        check("R10 in neg hold", fets_off, 1'b1);
        ldo_oc = 1'b1;
        @(negedge clk);
        ldo_oc = 1'b0;
        check("R10 shdn", reg_shdn, 1'b1);
        check("R10 fets_off dropped", fets_off, 1'b0);
        hiccup_walk("R10");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule